// File: doc/BRIEF.md
# Dual-input-qualified decade counter

A four-bit decimal counter that steps through 0 to 9 and then wraps. Counting is steered by two control inputs of opposite polarity. A rising level change on the first input advances the count while the second input is high. A falling level change on the second input advances the count while the first input is low. Either input can therefore act as the count clock, and the other then acts as its enable.

The block runs on a free-running system clock. Both control inputs are sampled through synchronizer flops, and their edges are found inside the block by comparing successive samples. The count leaves the block on registered outputs. A one-cycle terminal-count pulse marks each wrap from 9 to 0, so that a second copy can be chained for multistage counting or frequency division. An active-high master clear, together with the active-low system reset, forces the count to zero at once. Both are released in step with the system clock.

Top module: `decade_edge_counter`

## Requirements
- R1: While rst_ni is low, q_o is 0 and tc_o is 0.
- R2: A low-to-high change on cp0_i, made while cp1_i is high, raises q_o by one. The new value appears on the third rising clock edge after the change.
- R3: A high-to-low change on cp1_i, made while cp0_i is low, raises q_o by one, with the same latency as R2.
- R4: No other change holds q_o unchanged. This covers a falling cp0_i, a rising cp1_i, cp0_i rising while cp1_i is low, and cp1_i falling while cp0_i is high.
- R5: While mr_i is high, q_o is 0. It is forced there without waiting for a clock edge and stays 0 whatever cp0_i and cp1_i do.
- R6: A qualifying change while q_o is 9 returns q_o to 0.
- R7: tc_o is high for exactly one clock cycle, in the cycle where q_o goes from 9 to 0, and is low at all other times.
- R8: If cp0_i rises from low while cp1_i falls from high, with both changes at the same instant, q_o advances once.
- R9: Releasing mr_i or rst_ni leaves q_o at 0, whatever steady levels cp0_i and cp1_i hold.
- R10: q_o never holds a value above 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running system clock |
| rst_ni | input | 1 | Asynchronous system reset, active low |
| mr_i | input | 1 | Master clear, active high, overrides counting |
| cp0_i | input | 1 | Count input acting on its rising edge |
| cp1_i | input | 1 | Count input acting on its falling edge |
| q_o | output | 4 | Decimal count, bit 0 least significant |
| tc_o | output | 1 | One-cycle pulse on the wrap from 9 to 0 |

## Verification
The bench builds the block with its default parameters: a four-bit count ending at 9 and a two-stage synchronizer. With these values every transition from one level pair on the two inputs to another can be tried, with each starting pair repeated several times. Dedicated pulse trains drive the count through every value and across several wraps. Master clear is tested by applying it between clock edges, toggling the inputs while it is held, and releasing it with both inputs high.

// File: rtl/decade_pkg.sv
package decade_pkg;
  localparam int unsigned LVL_CP0 = 0;
  localparam int unsigned LVL_CP1 = 1;
  typedef logic [1:0] lvl_t;
endpackage

// File: rtl/dec_sync.sv
module dec_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i) stage_q[0] <= d_i;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i) stage_q[s] <= stage_q[s-1];
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/dec_rst_sync.sv
module dec_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic run_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sh_q <= '0;
    else          sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign run_o = sh_q[STAGES-1];
endmodule

// File: rtl/dec_edge_qual.sv
module dec_edge_qual
  import decade_pkg::*;
(
  input  logic clk_i,
  input  logic run_i,
  input  lvl_t lvl_i,
  output logic adv_o
);
  lvl_t prev_q;
  logic rise0, fall1;

  // history tracks the live level even in reset, so release sees no edge
  always_ff @(posedge clk_i) prev_q <= lvl_i;

  // qualify on the other input's level held before this sample
  assign rise0 = lvl_i[LVL_CP0] & ~prev_q[LVL_CP0] & prev_q[LVL_CP1];
  assign fall1 = ~lvl_i[LVL_CP1] & prev_q[LVL_CP1] & ~prev_q[LVL_CP0];
  assign adv_o = run_i & (rise0 | fall1);
endmodule

// File: rtl/dec_counter.sv
module dec_counter #(
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned LAST_VAL = 9
) (
  input  logic             clk_i,
  input  logic             run_i,
  input  logic             adv_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tc_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LAST_VAL);

  logic [CNT_W-1:0] cnt_q;
  logic             tc_q;

  always_ff @(posedge clk_i or negedge run_i) begin
    if (!run_i) begin
      cnt_q <= '0;
      tc_q  <= 1'b0;
    end else if (adv_i) begin
      // out-of-range values fall back to zero as well
      cnt_q <= (cnt_q >= LAST) ? '0 : cnt_q + 1'b1;
      tc_q  <= (cnt_q == LAST);
    end else begin
      tc_q  <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
  assign tc_o  = tc_q;
endmodule

// File: rtl/decade_edge_counter.sv
module decade_edge_counter
  import decade_pkg::*;
#(
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned LAST_VAL    = 9,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mr_i,
  input  logic             cp0_i,
  input  logic             cp1_i,
  output logic [CNT_W-1:0] q_o,
  output logic             tc_o
);
  logic arst_n, run;
  lvl_t lvl_raw, lvl_s;
  logic adv;

  assign arst_n  = rst_ni & ~mr_i;
  assign lvl_raw = {cp1_i, cp0_i};

  dec_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i  (clk_i),
    .arst_ni(arst_n),
    .run_o  (run)
  );

  dec_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i),
    .d_i  (lvl_raw),
    .q_o  (lvl_s)
  );

  dec_edge_qual u_qual (
    .clk_i(clk_i),
    .run_i(run),
    .lvl_i(lvl_s),
    .adv_o(adv)
  );

  dec_counter #(.CNT_W(CNT_W), .LAST_VAL(LAST_VAL)) u_cnt (
    .clk_i(clk_i),
    .run_i(run),
    .adv_i(adv),
    .cnt_o(q_o),
    .tc_o (tc_o)
  );
endmodule

// File: rtl/decade_edge_counter_chk.sv
module decade_edge_counter_chk #(
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned LAST_VAL = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mr_i,
  input logic [CNT_W-1:0] q_o,
  input logic             tc_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LAST_VAL);

  a_r10_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_o <= LAST);

  a_r5_clear_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mr_i |-> (q_o == '0 && !tc_o));

  a_r7_tc_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni || mr_i)
    tc_o |-> (q_o == '0 && $past(q_o) == LAST));

  a_r7_tc_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |=> !tc_o);

  a_r2_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni || mr_i)
    (q_o != $past(q_o)) |-> (q_o == $past(q_o) + 1'b1 || q_o == '0));
endmodule

bind decade_edge_counter decade_edge_counter_chk #(
  .CNT_W(CNT_W), .LAST_VAL(LAST_VAL)
) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .mr_i  (mr_i),
  .q_o   (q_o),
  .tc_o  (tc_o)
);

// File: tb/decade_edge_counter_test.sv
`timescale 1ns/1ps
module decade_edge_counter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mr = 1'b0;
  logic       cp0 = 1'b0;
  logic       cp1 = 1'b0;
  logic [3:0] q;
  logic       tc;

  int n_chk = 0;
  int n_bad = 0;
  int exp_q = 0;
  logic p0 = 1'b0;
  logic p1 = 1'b0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  decade_edge_counter uut (
    .clk_i(clk), .rst_ni(rst_n), .mr_i(mr),
    .cp0_i(cp0), .cp1_i(cp1), .q_o(q), .tc_o(tc)
  );

  task automatic chk(input int act, input int expv, input string tag);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic step(input logic c0, input logic c1);
    logic r0, r1, wrap;
    int tcs;
    string tag;
    @(negedge clk);
    cp0 = c0; cp1 = c1;
    r0 = !p0 && c0 && p1;
    r1 = p1 && !c1 && !p0;
    tcs = 0;
    repeat (5) begin
      @(negedge clk);
      if (tc) tcs++;
    end
    wrap = (r0 || r1) && exp_q == 9;
    if (r0 || r1) exp_q = (exp_q + 1) % 10;
    if (wrap)           tag = "R6 wrap";
    else if (r0 && r1)  tag = "R8 both edges";
    else if (r0)        tag = "R2 cp0 rise";
    else if (r1)        tag = "R3 cp1 fall";
    else                tag = "R4 hold";
    chk(int'(q), exp_q, tag);
    chk(tcs, wrap ? 1 : 0, "R7 tc pulse count");
    chk(int'(q) <= 9 ? 1 : 0, 1, "R10 range");
    p0 = c0; p1 = c1;
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(int'(q), 0, "R1 reset q");
    chk(int'(tc), 0, "R1 reset tc");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(int'(q), 0, "R9 release from reset");

    // every level-pair transition, repeated
    for (int rep = 0; rep < 3; rep++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++) begin
          step(i[0], i[1]);
          step(j[0], j[1]);
        end

    // cp0 as clock, cp1 as enable
    step(1'b0, 1'b1);
    for (int k = 0; k < 23; k++) begin
      step(1'b1, 1'b1);
      step(1'b0, 1'b1);
    end
    // cp1 as clock, cp0 low as enable
    step(1'b0, 1'b1);
    for (int k = 0; k < 14; k++) begin
      step(1'b0, 1'b0);
      step(1'b0, 1'b1);
    end
    // enable inactive: pulses ignored
    step(1'b0, 1'b0);
    for (int k = 0; k < 4; k++) begin
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
    end

    // master clear mid-cycle, async
    if (exp_q == 0) begin
      step(1'b0, 1'b1);
      step(1'b1, 1'b1);
    end
    @(negedge clk);
    #3 mr = 1'b1;
    #1 chk(int'(q), 0, "R5 async clear");
    exp_q = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      cp0 = k[0]; cp1 = ~k[1];
      repeat (3) @(negedge clk);
      chk(int'(q), 0, "R5 clear overrides edges");
    end
    @(negedge clk);
    cp0 = 1'b1; cp1 = 1'b1;
    repeat (4) @(negedge clk);
    mr = 1'b0;
    repeat (6) @(negedge clk);
    chk(int'(q), 0, "R9 release with inputs high");
    p0 = 1'b1; p1 = 1'b1;
    step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    step(1'b1, 1'b0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule